// File: doc/BRIEF.md
# Complementary Output Dead-Time Stage

This block takes the PWM reference of one timer channel and drives two pins from it: a main output that follows the reference and a complementary output that follows its inverse. A dead time is inserted at every reference transition. The output that is about to turn on waits a programmed interval after the other output has turned off, so the pair never conducts at the same time. This is the usual arrangement for driving the high and low switches of a half bridge.

The dead time is an 8-bit count of ticks. Each tick lasts one, two or four timer clocks, chosen by a division code. Each pin has its own polarity bit and its own enable bit. A master output enable gates both pins. While any gate is closed, a pin sits at its inactive level.

Top module: `cmp_deadtime_stage`

## Requirements
- R1: While reset is asserted, each pin sits at its inactive level, which equals its polarity bit.
- R2: While the master output enable `out_en` is 0, both pins are at their inactive levels whatever the reference does.
- R3: Clearing `main_en` forces only the main pin to its inactive level, and clearing `comp_en` forces only the complementary pin; the other pin keeps working.
- R4: A pin's level is its active state XOR its polarity bit, so polarity 0 means active high and polarity 1 means active low.
- R5: Let D be the dead-time value and N the division factor. After the first clock edge that samples the reference high, the complementary output is inactive, and the main output becomes active exactly D·N clock cycles later.
- R6: After the first clock edge that samples the reference low, the main output is inactive, and the complementary output becomes active exactly D·N clock cycles later.
- R7: Division code 0 gives N=1, code 1 gives N=2, and codes 2 and 3 give N=4.
- R8: With D=0 the outputs switch on the same clock edge that samples the reference change, with no gap.
- R9: A reference high pulse of L cycles produces a main active pulse of L−D·N cycles when L>D·N, and no main pulse at all when L≤D·N.
- R10: With both pins and the master gate enabled, the two outputs are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | PWM reference of the channel |
| dt_val | input | 8 | Dead-time length in ticks |
| div_sel | input | 2 | Tick division code (0:1, 1:2, 2/3:4) |
| main_pol | input | 1 | Main pin polarity, 1 = active low |
| comp_pol | input | 1 | Complementary pin polarity, 1 = active low |
| main_en | input | 1 | Main pin enable |
| comp_en | input | 1 | Complementary pin enable |
| out_en | input | 1 | Master output enable for both pins |
| main_pin | output | 1 | Main pin level |
| comp_pin | output | 1 | Complementary pin level |

## Verification
The edge properties assume that `dt_val` and `div_sel` do not change while a dead-time count is running. A change mid-count would make the interval a mix of two settings. The stimulus changes these settings only while the reference has been steady for longer than the full interval. The reference, the enables and the polarity bits are driven on the falling clock edge. Each of them therefore holds for a whole cycle and is sampled cleanly by the rising edge.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;
  // width of the tick prescaler, enough for the largest division (4)
  localparam int PRE_W = 2;

  // terminal value of the prescaler for a division code
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] code);
    case (code)
      2'd0:    return PRE_W'(0);
      2'd1:    return PRE_W'(1);
      default: return PRE_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler
  import deadtime_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(div_sel);
  assign tick = (pre_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/dt_edge_timer.sv
module dt_edge_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_in,
  input  logic [DT_W-1:0] dt_val,
  input  logic            tick,
  output logic            edge_evt,
  output logic            busy,
  output logic            main_act,
  output logic            comp_act
);
  localparam logic [DT_W-1:0] LAST = DT_W'(1);

  logic            ref_q;
  logic [DT_W-1:0] cnt_q;

  assign edge_evt = ref_in ^ ref_q;
  assign busy     = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      cnt_q    <= '0;
      main_act <= 1'b0;
      comp_act <= 1'b0;
    end else begin
      ref_q <= ref_in;
      if (edge_evt) begin
        cnt_q <= dt_val;
        if (dt_val == '0) begin
          main_act <= ref_in;
          comp_act <= ~ref_in;
        end else begin
          main_act <= 1'b0;
          comp_act <= 1'b0;
        end
      end else if (busy) begin
        if (tick) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LAST) begin
            main_act <= ref_q;
            comp_act <= ~ref_q;
          end
        end
      end else begin
        main_act <= ref_q;
        comp_act <= ~ref_q;
      end
    end
  end
endmodule

// File: rtl/dt_out_gate.sv
module dt_out_gate (
  input  logic act,
  input  logic en,
  input  logic master,
  input  logic pol,
  output logic pin
);
  assign pin = (act & en & master) ^ pol;
endmodule

// File: rtl/cmp_deadtime_stage.sv
module cmp_deadtime_stage #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_in,
  input  logic [DT_W-1:0] dt_val,
  input  logic [1:0]      div_sel,
  input  logic            main_pol,
  input  logic            comp_pol,
  input  logic            main_en,
  input  logic            comp_en,
  input  logic            out_en,
  output logic            main_pin,
  output logic            comp_pin
);
  localparam int NOUT = 2;

  logic            edge_evt;
  logic            tick;
  logic            busy;
  logic            main_act;
  logic            comp_act;
  logic [NOUT-1:0] act_v, en_v, pol_v, pin_v;

  dt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(edge_evt), .div_sel(div_sel), .tick(tick)
  );

  dt_edge_timer #(.DT_W(DT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dt_val(dt_val), .tick(tick),
    .edge_evt(edge_evt), .busy(busy), .main_act(main_act), .comp_act(comp_act)
  );

  assign act_v = {comp_act, main_act};
  assign en_v  = {comp_en, main_en};
  assign pol_v = {comp_pol, main_pol};

  for (genvar g = 0; g < NOUT; g++) begin : g_gate
    dt_out_gate u_gate (
      .act(act_v[g]), .en(en_v[g]), .master(out_en), .pol(pol_v[g]), .pin(pin_v[g])
    );
  end

  assign main_pin = pin_v[0];
  assign comp_pin = pin_v[1];
endmodule

// File: rtl/cmp_deadtime_chk.sv
module cmp_deadtime_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_in,
  input logic [DT_W-1:0] dt_val,
  input logic            edge_evt,
  input logic            tick,
  input logic            busy,
  input logic            main_act,
  input logic            comp_act,
  input logic            main_pol,
  input logic            comp_pol,
  input logic            main_en,
  input logic            comp_en,
  input logic            out_en,
  input logic            main_pin,
  input logic            comp_pin
);
  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && main_en && comp_en) |-> !((main_pin ^ main_pol) && (comp_pin ^ comp_pol)));

  // R2
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (main_pin == main_pol) && (comp_pin == comp_pol));

  // R5
  edge_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && dt_val != '0) |=> !main_act && !comp_act);

  // R5
  main_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_act) |-> $past(ref_in));

  // R6
  comp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_act) |-> !$past(ref_in));

  // R8
  zero_dt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && dt_val == '0) |=> (main_act == $past(ref_in)) && (comp_act != $past(ref_in)));

  // R7
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !edge_evt) |=> busy);
endmodule

bind cmp_deadtime_stage cmp_deadtime_chk #(.DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dt_val(dt_val),
  .edge_evt(edge_evt), .tick(tick), .busy(busy),
  .main_act(main_act), .comp_act(comp_act),
  .main_pol(main_pol), .comp_pol(comp_pol),
  .main_en(main_en), .comp_en(comp_en), .out_en(out_en),
  .main_pin(main_pin), .comp_pin(comp_pin)
);

// File: tb/cmp_deadtime_stage_bench.sv
module cmp_deadtime_stage_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic [7:0] dt_val = '0;
  logic [1:0] div_sel = '0;
  logic       main_pol = 1'b0, comp_pol = 1'b0;
  logic       main_en = 1'b1, comp_en = 1'b1, out_en = 1'b1;
  logic       main_pin, comp_pin;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cmp_deadtime_stage u_cmp_deadtime_stage (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dt_val(dt_val), .div_sel(div_sel),
    .main_pol(main_pol), .comp_pol(comp_pol), .main_en(main_en), .comp_en(comp_en),
    .out_en(out_en), .main_pin(main_pin), .comp_pin(comp_pin)
  );

  // table entry: {dead time, division code, high pulse length}
  localparam logic [25:0] VEC [0:9] = '{
    {8'd0,   2'd0, 16'd5},
    {8'd3,   2'd0, 16'd10},
    {8'd3,   2'd1, 16'd10},
    {8'd3,   2'd2, 16'd10},
    {8'd2,   2'd3, 16'd10},
    {8'd5,   2'd0, 16'd5},
    {8'd5,   2'd0, 16'd4},
    {8'd4,   2'd1, 16'd9},
    {8'd255, 2'd0, 16'd300},
    {8'd200, 2'd2, 16'd900}
  };

  function automatic int factor(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int cycles);
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_pulse(input logic [7:0] d, input logic [1:0] c, input int len);
    int dn = int'(d) * factor(c);
    int main_cnt = 0, main_first = -1, comp_off = 0, overlap = 0;
    dt_val = d; div_sel = c; ref_in = 1'b0;
    settle(dn + 4);
    ref_in = 1'b1;
    for (int i = 0; i < len + dn + 3; i++) begin
      @(posedge clk); @(negedge clk);
      if (main_pin) begin
        main_cnt++;
        if (main_first < 0) main_first = i;
      end
      if (!comp_pin) comp_off++;
      if (main_pin && comp_pin) overlap++;
      if (i == len - 1) ref_in = 1'b0;
    end
    // R5 R9: delayed start and shortened main pulse
    check("R9 main pulse length", main_cnt, (len > dn) ? len - dn : 0);
    if (len > dn) check("R5 R7 R8 main start delay", main_first, dn);
    // R6: complementary returns D*N after the falling edge
    check("R6 comp off length", comp_off, len + dn);
    // R10
    check("R10 no overlap", overlap, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state follows polarity
    main_pol = 1'b1; comp_pol = 1'b0;
    settle(3);
    check("R1 main pin in reset", main_pin, 1);
    check("R1 comp pin in reset", comp_pin, 0);
    main_pol = 1'b0;
    rst_n = 1'b1;
    settle(2);

    for (int v = 0; v < 10; v++)
      run_pulse(VEC[v][25:18], VEC[v][17:16], int'(VEC[v][15:0]));

    // R2: master gate closed with active-low pins
    dt_val = 8'd2; div_sel = 2'd0; main_pol = 1'b1; comp_pol = 1'b1;
    out_en = 1'b0; ref_in = 1'b1;
    settle(8);
    check("R2 main gated", main_pin, 1);
    check("R2 comp gated", comp_pin, 1);
    // R4: open gate, active-low main active
    out_en = 1'b1;
    #1;
    check("R4 main active low", main_pin, 0);
    check("R4 comp inactive high", comp_pin, 1);
    ref_in = 1'b0;
    settle(8);
    check("R4 main inactive high", main_pin, 1);
    check("R4 comp active low", comp_pin, 0);

    // R3: independent enables
    main_pol = 1'b0; comp_pol = 1'b0; main_en = 1'b0; ref_in = 1'b1;
    settle(8);
    check("R3 main disabled", main_pin, 0);
    ref_in = 1'b0;
    settle(8);
    check("R3 comp still works", comp_pin, 1);
    main_en = 1'b1; comp_en = 1'b0;
    #1;
    check("R3 comp disabled", comp_pin, 0);
    check("R3 main unaffected", main_pin, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule